// File: doc/BRIEF.md
# USB Charger Detection Sequencer

This block classifies whatever is plugged into a USB 2.0 port as one of four charger kinds. It works through three timed stages, always in the same order. The first stage checks whether the data pins have made contact. The second is a primary probe and the third is a secondary probe. In each stage the block switches on a set of analog source, sink and pull-down enables in the PHY. When the stage window ends it samples one comparator output.

All stage timing is counted in pulses of an external millisecond tick. The block never counts raw clock cycles, so the windows keep their real-time length whatever the clock frequency. While a classification runs, the transceiver is held in non-driving mode. When the block finishes it releases the transceiver, pulses `done_o` for one cycle and holds the two-bit result on `chg_type_o` until the next run completes. A synchronous abort drops everything back to idle.

Top module: `chgdet_seq`

## Requirements
- R1: After reset every enable output, `xcvr_nondrive_o` and `done_o` are low, and `chg_type_o` is 0.
- R2: When idle, a `start_i` pulse makes the block enter the contact stage on the next cycle. In that stage `xcvr_nondrive_o`, `dm_pulldown_en_o` and `dp_isrc_en_o` are high, and both attempt counters are cleared. A `start_i` pulse during a run has no effect on the result or the stage lengths.
- R3: In the contact stage, `dp_contact_i` is sampled after every 100 ticks, and at most 6 samples are taken. The stage ends on the first sample that shows contact, or on the sixth sample, whichever comes first.
- R4: The primary stage holds `dp_vsrc_en_o` and `dm_isink_en_o` high for a 40-tick window, then samples `primary_cmp_i`.
- R5: Suppose a primary sample is negative and the contact stage ended before its sixth sample. The window is then repeated, up to 2 extra times (3 windows in total). If every window is negative, the result is SDP, code 0.
- R6: Suppose the contact stage ended on its sixth sample, whatever `dp_contact_i` showed at that sample. A negative primary sample then ends the run after that single window, with result floating, code 3.
- R7: A positive primary sample starts the secondary stage. It holds `dm_vsrc_en_o` and `dp_isink_en_o` high for 40 ticks, then samples `secondary_cmp_i`: high gives DCP (code 1), low gives CDP (code 2).
- R8: A run ends with `done_o` high for exactly one cycle. `chg_type_o` updates in that same cycle and holds until the next completion, and `xcvr_nondrive_o` is low from that cycle on.
- R9: At most one stage's enables are high at any time, and `xcvr_nondrive_o` is high whenever any enable is high.
- R10: Only cycles with `tick_i` high advance a stage window. Cycles without a tick leave the stage and the enables unchanged.
- R11: `abort_i` returns the block to idle on the next cycle, with all enables and `xcvr_nondrive_o` low. It gives no `done_o` pulse and leaves `chg_type_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a classification when idle |
| abort_i | input | 1 | Synchronous abort to idle |
| tick_i | input | 1 | Millisecond tick, one cycle wide |
| dp_contact_i | input | 1 | D+ contact status from the analog front end |
| primary_cmp_i | input | 1 | Primary probe comparator |
| secondary_cmp_i | input | 1 | Secondary probe comparator |
| xcvr_nondrive_o | output | 1 | Hold the transceiver in non-driving mode |
| dm_pulldown_en_o | output | 1 | D- pull-down for contact detection |
| dp_isrc_en_o | output | 1 | D+ current source for contact detection |
| dp_vsrc_en_o | output | 1 | D+ voltage source, primary probe |
| dm_isink_en_o | output | 1 | D- current sink, primary probe |
| dm_vsrc_en_o | output | 1 | D- voltage source, secondary probe |
| dp_isink_en_o | output | 1 | D+ current sink, secondary probe |
| done_o | output | 1 | One-cycle completion strobe |
| chg_type_o | output | 2 | Result: 0 SDP, 1 DCP, 2 CDP, 3 floating |

## Verification
The bench measures the ticks spent with each stage's enables high, so any error in window length shows up as a wrong count. A timer that reloaded one tick short, or that counted raw cycles under a gated tick, would produce wrong counts. The timeout corner is driven with contact appearing exactly on the sixth sample. A design that tested the contact value rather than the sample count there would report SDP instead of floating. The bench also drives primary results that turn positive only on the third window. A retry limit off by one would end the run as SDP, or run a fourth window. Mid-run start pulses and an abort check that the run keeps its timing, and that the held result survives an abort.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_CONTACT   = 2'd1,
        PH_PRIMARY   = 2'd2,
        PH_SECONDARY = 2'd3
    } chg_phase_e;

    typedef enum logic [1:0] {
        KIND_SDP   = 2'd0,
        KIND_DCP   = 2'd1,
        KIND_CDP   = 2'd2,
        KIND_FLOAT = 2'd3
    } chg_kind_e;

    typedef struct packed {
        logic dm_pulldown;
        logic dp_isrc;
        logic dp_vsrc;
        logic dm_isink;
        logic dm_vsrc;
        logic dp_isink;
    } chg_drive_s;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/chgdet_timer.sv
module chgdet_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // Fires on the tick that consumes the last remaining count.
    assign expire = tick && (cnt_q == W'(1));

endmodule

// File: rtl/chgdet_fsm.sv
module chgdet_fsm
    import chgdet_pkg::*;
#(
    parameter int CONTACT_TICKS   = 100,
    parameter int PRIMARY_TICKS   = 40,
    parameter int SECONDARY_TICKS = 40,
    parameter int CONTACT_POLLS   = 6,
    parameter int PRIMARY_RETRIES = 2,
    parameter int TW              = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic          expire,
    input  logic          contact,
    input  logic          pri_cmp,
    input  logic          sec_cmp,
    output chg_phase_e    phase,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          done,
    output chg_kind_e     kind
);
    localparam int POLL_W  = $clog2(CONTACT_POLLS + 1);
    localparam int RETRY_W = $clog2(PRIMARY_RETRIES + 1);

    chg_phase_e         phase_q, phase_d;
    chg_kind_e          kind_q, kind_d;
    logic [POLL_W-1:0]  polls_q, polls_d;
    logic [RETRY_W-1:0] retries_q, retries_d;
    logic               tmo_q, tmo_d;
    logic               done_q, done_d;
    logic               last_poll;

    assign last_poll = (polls_q == POLL_W'(CONTACT_POLLS - 1));

    always_comb begin
        phase_d   = phase_q;
        kind_d    = kind_q;
        polls_d   = polls_q;
        retries_d = retries_q;
        tmo_d     = tmo_q;
        done_d    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        if (abort) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_d   = PH_CONTACT;
                        polls_d   = '0;
                        retries_d = '0;
                        tmo_d     = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(CONTACT_TICKS);
                    end
                end
                PH_CONTACT: begin
                    if (expire) begin
                        tmr_load = 1'b1;
                        if (contact || last_poll) begin
                            phase_d = PH_PRIMARY;
                            tmo_d   = last_poll;
                            tmr_val = TW'(PRIMARY_TICKS);
                        end else begin
                            polls_d = polls_q + POLL_W'(1);
                            tmr_val = TW'(CONTACT_TICKS);
                        end
                    end
                end
                PH_PRIMARY: begin
                    if (expire) begin
                        if (pri_cmp) begin
                            phase_d  = PH_SECONDARY;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(SECONDARY_TICKS);
                        end else if (tmo_q) begin
                            phase_d = PH_IDLE;
                            done_d  = 1'b1;
                            kind_d  = KIND_FLOAT;
                        end else if (retries_q < RETRY_W'(PRIMARY_RETRIES)) begin
                            retries_d = retries_q + RETRY_W'(1);
                            tmr_load  = 1'b1;
                            tmr_val   = TW'(PRIMARY_TICKS);
                        end else begin
                            phase_d = PH_IDLE;
                            done_d  = 1'b1;
                            kind_d  = KIND_SDP;
                        end
                    end
                end
                PH_SECONDARY: begin
                    if (expire) begin
                        phase_d = PH_IDLE;
                        done_d  = 1'b1;
                        kind_d  = sec_cmp ? KIND_DCP : KIND_CDP;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            kind_q    <= KIND_SDP;
            polls_q   <= '0;
            retries_q <= '0;
            tmo_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            kind_q    <= kind_d;
            polls_q   <= polls_d;
            retries_q <= retries_d;
            tmo_q     <= tmo_d;
            done_q    <= done_d;
        end
    end

    assign phase = phase_q;
    assign done  = done_q;
    assign kind  = kind_q;

endmodule

// File: rtl/chgdet_drive.sv
module chgdet_drive
    import chgdet_pkg::*;
(
    input  chg_phase_e phase,
    output chg_drive_s drv,
    output logic       nondrive
);
    always_comb begin
        drv = '0;
        unique case (phase)
            PH_CONTACT: begin
                drv.dm_pulldown = 1'b1;
                drv.dp_isrc     = 1'b1;
            end
            PH_PRIMARY: begin
                drv.dp_vsrc  = 1'b1;
                drv.dm_isink = 1'b1;
            end
            PH_SECONDARY: begin
                drv.dm_vsrc  = 1'b1;
                drv.dp_isink = 1'b1;
            end
            default: drv = '0;
        endcase
    end

    assign nondrive = (phase != PH_IDLE);

endmodule

// File: rtl/chgdet_seq.sv
module chgdet_seq
    import chgdet_pkg::*;
#(
    parameter int CONTACT_TICKS   = 100,
    parameter int PRIMARY_TICKS   = 40,
    parameter int SECONDARY_TICKS = 40,
    parameter int CONTACT_POLLS   = 6,
    parameter int PRIMARY_RETRIES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       abort_i,
    input  logic       tick_i,
    input  logic       dp_contact_i,
    input  logic       primary_cmp_i,
    input  logic       secondary_cmp_i,
    output logic       xcvr_nondrive_o,
    output logic       dm_pulldown_en_o,
    output logic       dp_isrc_en_o,
    output logic       dp_vsrc_en_o,
    output logic       dm_isink_en_o,
    output logic       dm_vsrc_en_o,
    output logic       dp_isink_en_o,
    output logic       done_o,
    output logic [1:0] chg_type_o
);
    localparam int MAX_TICKS = max3(CONTACT_TICKS, PRIMARY_TICKS, SECONDARY_TICKS);
    localparam int TW        = $clog2(MAX_TICKS + 1);

    chg_phase_e    phase;
    chg_kind_e     kind;
    chg_drive_s    drv;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          expire;

    chgdet_timer #(.W(TW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick_i),
        .expire   (expire)
    );

    chgdet_fsm #(
        .CONTACT_TICKS   (CONTACT_TICKS),
        .PRIMARY_TICKS   (PRIMARY_TICKS),
        .SECONDARY_TICKS (SECONDARY_TICKS),
        .CONTACT_POLLS   (CONTACT_POLLS),
        .PRIMARY_RETRIES (PRIMARY_RETRIES),
        .TW              (TW)
    ) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .abort    (abort_i),
        .expire   (expire),
        .contact  (dp_contact_i),
        .pri_cmp  (primary_cmp_i),
        .sec_cmp  (secondary_cmp_i),
        .phase    (phase),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .done     (done_o),
        .kind     (kind)
    );

    chgdet_drive i_drive (
        .phase    (phase),
        .drv      (drv),
        .nondrive (xcvr_nondrive_o)
    );

    assign dm_pulldown_en_o = drv.dm_pulldown;
    assign dp_isrc_en_o     = drv.dp_isrc;
    assign dp_vsrc_en_o     = drv.dp_vsrc;
    assign dm_isink_en_o    = drv.dm_isink;
    assign dm_vsrc_en_o     = drv.dm_vsrc;
    assign dp_isink_en_o    = drv.dp_isink;
    assign chg_type_o       = kind;

endmodule

// File: rtl/chgdet_seq_checks.sv
module chgdet_seq_checks (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       abort_i,
    input logic       tick_i,
    input logic       xcvr_nondrive_o,
    input logic       dm_pulldown_en_o,
    input logic       dp_isrc_en_o,
    input logic       dp_vsrc_en_o,
    input logic       dm_isink_en_o,
    input logic       dm_vsrc_en_o,
    input logic       dp_isink_en_o,
    input logic       done_o,
    input logic [1:0] chg_type_o
);
    logic any_en;
    assign any_en = dm_pulldown_en_o | dp_isrc_en_o | dp_vsrc_en_o |
                    dm_isink_en_o | dm_vsrc_en_o | dp_isink_en_o;

    p_start_contact_r2: assert property (@(posedge clk) disable iff (rst)
        (!xcvr_nondrive_o && start_i && !abort_i) |=>
            (xcvr_nondrive_o && dm_pulldown_en_o && dp_isrc_en_o));

    p_contact_to_primary_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(dp_isrc_en_o) && !$past(abort_i)) |-> (dp_vsrc_en_o && dm_isink_en_o));

    p_secondary_result_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(dm_vsrc_en_o) && !$past(abort_i)) |->
            (done_o && (chg_type_o == 2'd1 || chg_type_o == 2'd2)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_type_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(chg_type_o));

    p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !xcvr_nondrive_o);

    p_stage_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dp_isrc_en_o, dp_vsrc_en_o, dm_vsrc_en_o}));

    p_nondrive_cover_r9: assert property (@(posedge clk) disable iff (rst)
        any_en |-> xcvr_nondrive_o);

    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (xcvr_nondrive_o && !tick_i && !abort_i) |=>
            ($stable({dp_isrc_en_o, dp_vsrc_en_o, dm_vsrc_en_o}) && !done_o));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!xcvr_nondrive_o && !any_en && !done_o));

endmodule

bind chgdet_seq chgdet_seq_checks i_chgdet_seq_checks (
    .clk              (clk),
    .rst              (rst),
    .start_i          (start_i),
    .abort_i          (abort_i),
    .tick_i           (tick_i),
    .xcvr_nondrive_o  (xcvr_nondrive_o),
    .dm_pulldown_en_o (dm_pulldown_en_o),
    .dp_isrc_en_o     (dp_isrc_en_o),
    .dp_vsrc_en_o     (dp_vsrc_en_o),
    .dm_isink_en_o    (dm_isink_en_o),
    .dm_vsrc_en_o     (dm_vsrc_en_o),
    .dp_isink_en_o    (dp_isink_en_o),
    .done_o           (done_o),
    .chg_type_o       (chg_type_o)
);

// File: tb/test_chgdet_seq.sv
module test_chgdet_seq;

    localparam int NEVER = 1000000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       abort_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       dp_contact_i = 1'b0;
    logic       primary_cmp_i = 1'b0;
    logic       secondary_cmp_i = 1'b0;
    logic       xcvr_nondrive_o;
    logic       dm_pulldown_en_o;
    logic       dp_isrc_en_o;
    logic       dp_vsrc_en_o;
    logic       dm_isink_en_o;
    logic       dm_vsrc_en_o;
    logic       dp_isink_en_o;
    logic       done_o;
    logic [1:0] chg_type_o;

    chgdet_seq i_chgdet_seq (
        .clk              (clk),
        .rst              (rst),
        .start_i          (start_i),
        .abort_i          (abort_i),
        .tick_i           (tick_i),
        .dp_contact_i     (dp_contact_i),
        .primary_cmp_i    (primary_cmp_i),
        .secondary_cmp_i  (secondary_cmp_i),
        .xcvr_nondrive_o  (xcvr_nondrive_o),
        .dm_pulldown_en_o (dm_pulldown_en_o),
        .dp_isrc_en_o     (dp_isrc_en_o),
        .dp_vsrc_en_o     (dp_vsrc_en_o),
        .dm_isink_en_o    (dm_isink_en_o),
        .dm_vsrc_en_o     (dm_vsrc_en_o),
        .dp_isink_en_o    (dp_isink_en_o),
        .done_o           (done_o),
        .chg_type_o       (chg_type_o)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Monitor counters (written only by the monitor loop).
    int cyc = 0;
    int dcd_t = 0;
    int pri_t = 0;
    int sec_t = 0;
    int done_n = 0;
    int nd_bad = 0;
    int div_cnt = 0;

    // Scenario controls (written only by the main sequence).
    int tick_div = 1;
    int contact_after = NEVER;
    int pri_after = NEVER;
    int dcd_base = 0;
    int pri_base = 0;
    logic sec_val = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drives tick and comparator levels at the falling edge, and counts the
    // ticks each stage consumes at the following rising edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            div_cnt++;
            tick_i = (tick_div <= 1) ? 1'b1 : ((div_cnt % tick_div) == 0);
            if (tick_i && dp_isrc_en_o) dcd_t++;
            if (tick_i && dp_vsrc_en_o) pri_t++;
            if (tick_i && dm_vsrc_en_o) sec_t++;
            if (done_o) done_n++;
            if ((dm_pulldown_en_o | dp_isrc_en_o | dp_vsrc_en_o | dm_isink_en_o |
                 dm_vsrc_en_o | dp_isink_en_o) && !xcvr_nondrive_o) nd_bad++;
            dp_contact_i    = ((dcd_t - dcd_base) >= contact_after);
            primary_cmp_i   = ((pri_t - pri_base) >= pri_after);
            secondary_cmp_i = sec_val;
        end
    end

    initial begin
        wait (cyc > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic t_reset();
        check(!xcvr_nondrive_o, "R1", "nondrive after reset", int'(xcvr_nondrive_o), 0);
        check(!(dm_pulldown_en_o | dp_isrc_en_o | dp_vsrc_en_o | dm_isink_en_o |
                dm_vsrc_en_o | dp_isink_en_o), "R1", "enables after reset",
              int'(dp_isrc_en_o | dp_vsrc_en_o | dm_vsrc_en_o), 0);
        check(!done_o, "R1", "done after reset", int'(done_o), 0);
        check(chg_type_o == 2'd0, "R1", "type after reset", int'(chg_type_o), 0);
    endtask

    task automatic t_run(input string req, input int c_after, input int p_after,
                         input logic s_val, input int div, input bit extra_start,
                         input int exp_type, input int exp_dcd, input int exp_pri,
                         input int exp_sec);
        int d0, p0, s0, n0, b0, c0, elapsed;
        bit seen;
        @(negedge clk);
        tick_div      = div;
        contact_after = c_after;
        pri_after     = p_after;
        sec_val       = s_val;
        dcd_base      = dcd_t;
        pri_base      = pri_t;
        d0 = dcd_t; p0 = pri_t; s0 = sec_t; n0 = done_n; b0 = nd_bad; c0 = cyc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(xcvr_nondrive_o && dm_pulldown_en_o && dp_isrc_en_o, "R2",
              "contact stage entry", int'({xcvr_nondrive_o, dm_pulldown_en_o, dp_isrc_en_o}), 7);
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            if (extra_start && i == 150) start_i = 1'b1;
            if (extra_start && i == 151) start_i = 1'b0;
            @(negedge clk);
            seen = done_o;
        end
        elapsed = cyc - c0;
        check(seen, "R8", "done seen", int'(seen), 1);
        check(!xcvr_nondrive_o, "R8", "nondrive released at done", int'(xcvr_nondrive_o), 0);
        check(int'(chg_type_o) == exp_type, req, "charger type", int'(chg_type_o), exp_type);
        check(dcd_t - d0 == exp_dcd, "R3", "contact ticks", dcd_t - d0, exp_dcd);
        check(pri_t - p0 == exp_pri, "R4", "primary ticks", pri_t - p0, exp_pri);
        check(sec_t - s0 == exp_sec, "R7", "secondary ticks", sec_t - s0, exp_sec);
        if (div > 1) begin
            int tot = exp_dcd + exp_pri + exp_sec;
            check(elapsed >= div * tot - div && elapsed <= div * tot + div, "R10",
                  "cycles under gated tick", elapsed, div * tot);
        end
        repeat (3) @(negedge clk);
        check(done_n - n0 == 1, "R8", "done pulse count", done_n - n0, 1);
        check(int'(chg_type_o) == exp_type, "R8", "type held", int'(chg_type_o), exp_type);
        check(nd_bad == b0, "R9", "enable without nondrive", nd_bad - b0, 0);
    endtask

    task automatic t_abort();
        int n0;
        logic [1:0] prev;
        @(negedge clk);
        tick_div = 1;
        contact_after = NEVER;
        pri_after = NEVER;
        dcd_base = dcd_t;
        pri_base = pri_t;
        prev = chg_type_o;
        n0 = done_n;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(!xcvr_nondrive_o && !dp_isrc_en_o && !dm_pulldown_en_o, "R11",
              "idle after abort", int'({xcvr_nondrive_o, dp_isrc_en_o}), 0);
        repeat (800) @(negedge clk);
        check(done_n == n0, "R11", "no done after abort", done_n - n0, 0);
        check(chg_type_o == prev, "R11", "type kept after abort", int'(chg_type_o), int'(prev));
        check(!xcvr_nondrive_o, "R11", "still idle", int'(xcvr_nondrive_o), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        // SDP: contact at first sample, primary never positive (3 windows).
        t_run("R5", 1, NEVER, 1'b0, 1, 1'b0, 0, 100, 120, 0);
        // DCP and CDP from a positive primary.
        t_run("R7", 1, 1, 1'b1, 1, 1'b0, 1, 100, 40, 40);
        t_run("R7", 1, 1, 1'b0, 1, 1'b0, 2, 100, 40, 40);
        // Contact on third sample, primary positive only in third window.
        t_run("R5", 201, 81, 1'b1, 1, 1'b0, 1, 300, 120, 40);
        // Floating: no contact at all, primary negative.
        t_run("R6", NEVER, NEVER, 1'b0, 1, 1'b0, 3, 600, 40, 0);
        // Contact appearing only at the sixth sample still counts as timeout.
        t_run("R6", 501, NEVER, 1'b0, 1, 1'b0, 3, 600, 40, 0);
        // Timeout but primary positive goes on to secondary.
        t_run("R7", NEVER, 1, 1'b0, 1, 1'b0, 2, 600, 40, 40);
        // Gated tick: one tick every third cycle.
        t_run("R10", 101, 1, 1'b1, 3, 1'b0, 1, 200, 40, 40);
        // Start pulse during a run is ignored.
        t_run("R2", 1, NEVER, 1'b0, 1, 1'b1, 0, 100, 120, 0);
        // Abort mid contact stage, then a fresh run.
        t_abort();
        t_run("R7", 1, 1, 1'b0, 1, 1'b0, 2, 100, 40, 40);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule